// File: doc/BRIEF.md
# Reset Control Port Register

This block is a single byte-wide register that sits at I/O address 0x0CF9 on the processor's I/O read/write path. Software writes a byte to request a processor reset and can read the byte back at any time. Every write to the port is kept, and a read returns the value most recently written.

A reset is requested only when a write raises the reset-initiate bit, bit 2. The bit must be set in the incoming byte and clear in the byte already held. Bit 1 of that same write selects the kind of reset. When it is clear the reset is soft, and the block pulses only the processor reset request. When it is set the reset is hard. In that case the block first sends a one-cycle forced-write request to the configuration block, which loads the top-segment memory attribute register (configuration address 0x59) with 0x0F. The processor reset request follows one cycle later. Sequencing the processor through reset, and resetting other bus agents, are left to the surrounding logic.

Top module: `crp_reset_port`

## Requirements
- R1: A write to any I/O address other than 0x0CF9 changes neither the stored byte nor any reset output.
- R2: While `io_rd` is high with `io_addr` equal to 0x0CF9, `io_rdata_oe` is high and `io_rdata` equals the byte stored by the most recent accepted write.
- R3: While no read of 0x0CF9 is in progress, `io_rdata_oe` is low.
- R4: A synchronous reset (`rst_n` low at a clock edge) clears the stored byte to 0x00 and holds every reset output low. The first write after reset that has bit 2 set therefore triggers a reset.
- R5: A reset is triggered only by a write to 0x0CF9 that has bit 2 set while the stored byte has bit 2 clear. A write with bit 2 set while bit 2 is already stored triggers nothing.
- R6: Every write to 0x0CF9 replaces the stored byte, whether or not it triggers a reset.
- R7: A triggering write with bit 1 clear is a soft reset. It produces no `hard_reset` pulse and no forced configuration write.
- R8: A triggering write with bit 1 set produces a single-cycle `hard_reset` pulse. In that same cycle `cfg_force_we` is high, `cfg_force_addr` is 0x59 and `cfg_force_data` is 0x0F. Both of those buses are 0x00 when no forced write is issued.
- R9: `cpu_reset_req` is a single-cycle pulse. It is high in the second cycle after the clock edge that accepts the triggering write, one cycle after any `hard_reset` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid while io_rdata_oe is high |
| io_rdata_oe | output | 1 | High when this block drives the read data |
| cpu_reset_req | output | 1 | One-cycle processor reset request |
| hard_reset | output | 1 | One-cycle hard-reset indication |
| cfg_force_we | output | 1 | One-cycle forced write request to the configuration block |
| cfg_force_addr | output | 8 | Configuration register address of the forced write |
| cfg_force_data | output | 8 | Data of the forced write |

## Verification
The bench goes after four edge cases. The first is re-writing bit 2 while it is already stored. A level-sensitive design would fire a second reset there. The second is raising bit 2 on the cycle right after clearing it, where a design that compared against a stale copy would miss the trigger. The third is a write with bit 1 set but no rising bit 2. A design that keyed the hard reset on bit 1 alone would force the attribute register without any reset. The bench also writes to neighbouring addresses 0x0CF8 and 0x0CFA, which exposes a partial address decode through changed readback or stray pulses. Finally, it applies a mid-run reset and then writes bit 2, which catches a register that does not clear to zero and so swallows the first trigger.

// File: rtl/crp_pkg.sv
// Package: shared constants and types for the reset control port.
// Assumes a 16-bit I/O address space and byte-wide data.
package crp_pkg;
    localparam int          IO_ADDR_W    = 16;
    localparam int          IO_DATA_W    = 8;
    localparam int          CFG_ADDR_W   = 8;
    localparam logic [15:0] PORT_ADDR    = 16'h0CF9;
    localparam int          INIT_BIT     = 2;
    localparam int          HARD_BIT     = 1;
    localparam logic [7:0]  RESET_VALUE  = 8'h00;
    localparam logic [7:0]  FORCE_ADDR   = 8'h59;
    localparam logic [7:0]  FORCE_DATA   = 8'h0F;

    // Forced configuration write request.
    typedef struct packed {
        logic                  we;
        logic [CFG_ADDR_W-1:0] addr;
        logic [IO_DATA_W-1:0]  data;
    } cfg_force_t;
endpackage

// File: rtl/crp_decode.sv
// Module: crp_decode
// Matches the I/O address against the port address and qualifies the strobes.
// Assumes the address is stable while a strobe is high.
module crp_decode #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] MATCH  = 16'h0CF9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic addr_match;

    // Full-width compare and strobe qualification.
    always_comb begin
        addr_match = (io_addr == MATCH);
        wr_hit     = io_wr && addr_match;
        rd_hit     = io_rd && addr_match;
    end
endmodule

// File: rtl/crp_store.sv
// Module: crp_store
// Holds the port byte and spots a 0-to-1 change of the initiate bit on a write.
// Assumes wr_hit is a one-cycle qualified strobe; the compare uses the
// stored byte before this write's update.
module crp_store #(
    parameter int                 DATA_W    = 8,
    parameter int                 INIT_BIT  = 2,
    parameter int                 HARD_BIT  = 1,
    parameter logic [DATA_W-1:0]  RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored,
    output logic              trig,
    output logic              trig_hard
);
    logic [DATA_W-1:0] value_q;

    // Edge detection against the previously held byte.
    always_comb begin
        trig      = wr_hit && wdata[INIT_BIT] && !value_q[INIT_BIT];
        trig_hard = trig && wdata[HARD_BIT];
    end

    // Storage: every accepted write replaces the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= RESET_VAL;
        else if (wr_hit)
            value_q <= wdata;
    end

    assign stored = value_q;

    // R6
    store_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit)) |-> (value_q == $past(wdata)));

    // R5
    trig_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> value_q[INIT_BIT]);
endmodule

// File: rtl/crp_sequencer.sv
// Module: crp_sequencer
// Turns a trigger into timed pulses: forced config write and hard indication
// in the first cycle, processor reset request in the next.
// Assumes triggers are at least two cycles apart (guaranteed by the edge rule).
module crp_sequencer #(
    parameter int                    CFG_ADDR_W = 8,
    parameter int                    DATA_W     = 8,
    parameter logic [CFG_ADDR_W-1:0] F_ADDR     = 8'h59,
    parameter logic [DATA_W-1:0]     F_DATA     = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig,
    input  logic                  trig_hard,
    output logic                  hard_reset,
    output logic                  cpu_reset_req,
    output logic                  force_we,
    output logic [CFG_ADDR_W-1:0] force_addr,
    output logic [DATA_W-1:0]     force_data
);
    logic stage1_q;
    logic hard_q;
    logic cpu_q;

    // Two-stage pulse pipeline: hard/force first, processor request second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            hard_q   <= 1'b0;
            cpu_q    <= 1'b0;
        end else begin
            stage1_q <= trig;
            hard_q   <= trig_hard;
            cpu_q    <= stage1_q;
        end
    end

    // Forced write fields are driven only while the request is active.
    always_comb begin
        force_we   = hard_q;
        force_addr = hard_q ? F_ADDR : '0;
        force_data = hard_q ? F_DATA : '0;
    end

    assign hard_reset    = hard_q;
    assign cpu_reset_req = cpu_q;

    // R9
    hard_before_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_q |=> cpu_q);

    // R9
    cpu_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_q |=> !cpu_q);
endmodule

// File: rtl/crp_reset_port.sv
// Module: crp_reset_port (top)
// Reset control port register: decode, storage with edge detect, pulse sequencing.
// Assumes single-cycle I/O strobes and a synchronous active-low reset.
module crp_reset_port
    import crp_pkg::*;
#(
    parameter int                 ADDR_W  = IO_ADDR_W,
    parameter int                 DATA_W  = IO_DATA_W,
    parameter int                 CADDR_W = CFG_ADDR_W,
    parameter logic [ADDR_W-1:0]  PORT    = PORT_ADDR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    output logic               io_rdata_oe,
    output logic               cpu_reset_req,
    output logic               hard_reset,
    output logic               cfg_force_we,
    output logic [CADDR_W-1:0] cfg_force_addr,
    output logic [DATA_W-1:0]  cfg_force_data
);
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] stored;
    logic              trig;
    logic              trig_hard;

    crp_decode #(.ADDR_W(ADDR_W), .MATCH(PORT)) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    crp_store #(
        .DATA_W    (DATA_W),
        .INIT_BIT  (INIT_BIT),
        .HARD_BIT  (HARD_BIT),
        .RESET_VAL (DATA_W'(RESET_VALUE))
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (io_wdata),
        .stored    (stored),
        .trig      (trig),
        .trig_hard (trig_hard)
    );

    crp_sequencer #(
        .CFG_ADDR_W (CADDR_W),
        .DATA_W     (DATA_W),
        .F_ADDR     (CADDR_W'(FORCE_ADDR)),
        .F_DATA     (DATA_W'(FORCE_DATA))
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig          (trig),
        .trig_hard     (trig_hard),
        .hard_reset    (hard_reset),
        .cpu_reset_req (cpu_reset_req),
        .force_we      (cfg_force_we),
        .force_addr    (cfg_force_addr),
        .force_data    (cfg_force_data)
    );

    // Readback mux: drive the stored byte only during a decoded read.
    always_comb begin
        io_rdata_oe = rd_hit;
        io_rdata    = rd_hit ? stored : '0;
    end

    // R3
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (io_rd && io_addr == PORT));

    // R8
    hard_force_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset |-> (cfg_force_we && cfg_force_addr == CADDR_W'(FORCE_ADDR)
                        && cfg_force_data == DATA_W'(FORCE_DATA)));

    // R7
    force_only_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_we |-> hard_reset);

    // R1
    other_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != PORT && !trig) |=> !hard_reset);
endmodule

// File: tb/crp_reset_port_tb_top.sv
module crp_reset_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        cpu_reset_req;
    logic        hard_reset;
    logic        cfg_force_we;
    logic [7:0]  cfg_force_addr;
    logic [7:0]  cfg_force_data;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state
    logic [7:0] m_store = 8'h00;
    bit         m_pend = 0, m_hard = 0, m_cpu = 0;

    always #2 clk = ~clk;

    crp_reset_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .cpu_reset_req(cpu_reset_req), .hard_reset(hard_reset),
        .cfg_force_we(cfg_force_we), .cfg_force_addr(cfg_force_addr),
        .cfg_force_data(cfg_force_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock step: compare registered outputs, drive inputs, compare the read path, advance the model.
    task automatic step(input bit rn, input bit wr, input bit rd,
                        input logic [15:0] addr, input logic [7:0] data);
        bit trig;
        @(negedge clk);
        check("R9 cpu_reset_req (R5 trigger rule)", {15'd0, cpu_reset_req}, {15'd0, m_cpu});
        check("R8 hard_reset (R7 soft has none)", {15'd0, hard_reset}, {15'd0, m_hard});
        check("R8 cfg_force_we", {15'd0, cfg_force_we}, {15'd0, m_hard});
        check("R8 cfg_force_addr", {8'd0, cfg_force_addr}, m_hard ? 16'h0059 : 16'h0000);
        check("R8 cfg_force_data", {8'd0, cfg_force_data}, m_hard ? 16'h000F : 16'h0000);
        rst_n = rn; io_wr = wr; io_rd = rd; io_addr = addr; io_wdata = data;
        #1;
        check("R3 io_rdata_oe", {15'd0, io_rdata_oe}, {15'd0, (rd && addr == 16'h0CF9)});
        if (rd && addr == 16'h0CF9)
            check("R2 readback (R1 R6 stored byte)", {8'd0, io_rdata}, {8'd0, m_store});
        if (!rn) begin
            m_store = 8'h00; m_pend = 0; m_hard = 0; m_cpu = 0;
        end else begin
            trig   = wr && addr == 16'h0CF9 && data[2] && !m_store[2];
            m_cpu  = m_pend;
            m_pend = trig;
            m_hard = trig && data[1];
            if (wr && addr == 16'h0CF9) m_store = data;
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
        step(1, 1, 0, a, d);
    endtask
    task automatic rd_port(input logic [15:0] a);
        step(1, 0, 1, a, 8'h00);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 16'h0000, 8'h00);
    endtask

    initial begin
        #40000;
        fails++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(posedge clk);
        step(0, 0, 0, 16'h0, 8'h0);
        step(0, 1, 0, 16'h0CF9, 8'hFF);
        idle(1);
        // R4: reset state
        check("R4 reset cpu_reset_req", {15'd0, cpu_reset_req}, 16'd0);
        check("R4 reset hard_reset", {15'd0, hard_reset}, 16'd0);
        rd_port(16'h0CF9);                 // R4: reads 0x00
        wr_port(16'h0CF9, 8'h04);          // R7 soft reset
        idle(3);
        wr_port(16'h0CF9, 8'h04);          // R5 no retrigger
        wr_port(16'h0CF9, 8'h06);          // R5 bit 2 already set
        idle(2);
        rd_port(16'h0CF9);                 // R6 stored 06
        wr_port(16'h0CF9, 8'h00);
        wr_port(16'h0CF9, 8'h06);          // R8 hard
        idle(3);
        wr_port(16'h0CF8, 8'h00);          // R1
        wr_port(16'h0CFA, 8'h00);          // R1
        rd_port(16'h0CF9);
        rd_port(16'h0CF8);                 // R3
        wr_port(16'h0CF9, 8'h00);
        wr_port(16'h0CF9, 8'h02);          // bit 1 only: no reset
        idle(2);
        rd_port(16'h0CF9);
        wr_port(16'h0CF9, 8'h06);          // hard from stored 02
        idle(2);
        wr_port(16'h0CF9, 8'h00);
        wr_port(16'h0CF9, 8'h04);          // back-to-back soft
        idle(2);
        wr_port(16'h0CF8, 8'h04);          // R1 after clearing below
        wr_port(16'h0CF9, 8'hFB);          // bit 2 clear, others set
        wr_port(16'h0CF8, 8'h04);          // R1 no trigger
        wr_port(16'h0CFA, 8'h06);
        idle(2);
        rd_port(16'h0CF9);
        step(0, 0, 0, 16'h0, 8'h0);        // R4 mid-run reset
        rd_port(16'h0CF9);
        wr_port(16'h0CF9, 8'h04);          // R4 first trigger after reset
        idle(3);
        for (int v = 0; v < 16; v++) begin
            wr_port(16'h0CF9, 8'(v));
            rd_port(16'h0CF9);
        end
        idle(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule